// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block gathers the interrupt causes of a 16550-compatible serial port and presents the most urgent one as a 4-bit identification code, with an interrupt request line beside it. Five causes exist: receive line errors, receive data at or above the FIFO trigger level, receive character time-out, transmit holding register empty, and modem input change. Line errors, transmit empty and modem change are latched from single-cycle event pulses. Receive data is a level taken from the FIFO comparator. The time-out is produced inside the block by a character timer.

Every latched cause has its own clearing strobe, driven by the bus decoder of the surrounding port. The time-out timer counts baud ticks while the receive FIFO holds data, and it restarts on every push into or read from that FIFO. Its limit is four frames, where a frame length in bits is a run-time input. Per-source enable bits mask what is reported. They do not affect what is latched.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, or with nothing pending and enabled, `int_id` is 4'b0001 and `irq` is 0.
- R2: A `line_err` pulse latches the line-status cause (code 4'b0110), and `rd_lsr` clears it. Latched causes show on `int_id` after the rising edge that ends the pulse cycle.
- R3: While `rx_at_trigger` is 1, the data-available cause (code 4'b0100) is pending in the same cycle. It goes away as soon as the level drops.
- R4: In FIFO mode, with `rx_nonempty` high, the time-out cause (code 4'b1100) latches once 4*`frame_bits` baud-tick cycles have passed since the last `rx_push` or `rd_rbr`. It shows one edge after the count reaches that limit. `rd_rbr` clears it, and a push or read restarts the count.
- R5: A `thr_empty_evt` pulse latches the transmit-empty cause (code 4'b0010), and `wr_thr` clears it.
- R6: An `rd_iir` strobe clears the transmit-empty cause only if `int_id` shows 4'b0010 in the cycle of the strobe. Otherwise the cause stays latched.
- R7: A `modem_chg` pulse latches the modem cause (code 4'b0000), and `rd_msr` clears it.
- R8: The reported order is: line status, then data available, then time-out, then transmit empty, then modem.
- R9: `src_en` bit 0 enables line status, bit 1 data available, bit 2 time-out, bit 3 transmit empty and bit 4 modem. A disabled cause keeps its latched state and is reported once it is enabled again.
- R10: With `fifo_mode` low the time-out never latches, `int_id[3]` is 0, and a pending time-out is discarded.
- R11: When a latched cause sees its set pulse and its clear strobe in the same cycle, it ends up set.
- R12: `irq` is 1 exactly when some enabled cause is pending, that is, exactly when `int_id[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | FIFOs enabled |
| src_en | input | 5 | Per-cause enables (bit map in R9) |
| line_err | input | 1 | Overrun, parity, framing or break event pulse |
| rx_at_trigger | input | 1 | Receive level at or above trigger |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | Character written into receive FIFO |
| rd_rbr | input | 1 | Receive buffer read strobe |
| baud_tick | input | 1 | One pulse per bit time |
| frame_bits | input | FRAME_W | Bits per character frame |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| wr_thr | input | 1 | Transmit holding register write strobe |
| rd_iir | input | 1 | Identification register read strobe |
| modem_chg | input | 1 | CTS/DSR/RI/DCD change pulse |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| int_id | output | 4 | Identification code of highest pending cause |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the time-out boundary. No push or read may occur for exactly four frames of baud ticks while the FIFO is non-empty, and it is mixed with restarts and a leave of FIFO mode. The bench holds `baud_tick` high with a 10-bit frame. It samples once after 40 counted edges, where the code must still be idle, and once a single edge later, where the code must be 4'b1100. It then shows that a push partway through restarts the count, and that dropping `fifo_mode` throws away a pending time-out. The conditional clear on an identification read is reached by placing the read in a cycle where a higher-priority level masks the transmit-empty code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam logic [3:0] ID_NONE    = 4'b0001;
   localparam logic [3:0] ID_LINE    = 4'b0110;
   localparam logic [3:0] ID_RXDATA  = 4'b0100;
   localparam logic [3:0] ID_TIMEOUT = 4'b1100;
   localparam logic [3:0] ID_TXEMPTY = 4'b0010;
   localparam logic [3:0] ID_MODEM   = 4'b0000;
   // positions in the pending vector, highest priority first
   localparam int unsigned P_LINE    = 0;
   localparam int unsigned P_RXDATA  = 1;
   localparam int unsigned P_TIMEOUT = 2;
   localparam int unsigned P_TXEMPTY = 3;
   localparam int unsigned P_MODEM   = 4;
   localparam int unsigned SRC_N     = 5;
   // positions in the latched-flag vector
   localparam int unsigned F_LINE    = 0;
   localparam int unsigned F_TIMEOUT = 1;
   localparam int unsigned F_TXEMPTY = 2;
   localparam int unsigned F_MODEM   = 3;
   localparam int unsigned FLAG_N    = 4;
endpackage

// File: rtl/uart_irq_flagbank.sv
module uart_irq_flagbank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;   // set dominates a simultaneous clear
         else if (clr_i[i]) q <= 1'b0;
      end
      assign flag_o[i] = q;
   end
endmodule

// File: rtl/uart_irq_chartimer.sv
module uart_irq_chartimer #(
   parameter int unsigned FRAME_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               restart_i,
   input  logic               tick_i,
   input  logic [FRAME_W-1:0] frame_bits_i,
   output logic               expired_o
);
   localparam int unsigned CNT_W = FRAME_W + 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = {frame_bits_i, 2'b00};   // four frames

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (!run_i || restart_i) cnt_q <= '0;
      else if (tick_i && cnt_q != limit)
                                    cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && !restart_i && (limit != '0) && (cnt_q == limit);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic [SRC_N-1:0] pend_i,
   input  logic             fifo_mode_i,
   output logic [3:0]       id_o
);
   logic [3:0] raw;
   always_comb begin
      if      (pend_i[P_LINE])    raw = ID_LINE;
      else if (pend_i[P_RXDATA])  raw = ID_RXDATA;
      else if (pend_i[P_TIMEOUT]) raw = ID_TIMEOUT;
      else if (pend_i[P_TXEMPTY]) raw = ID_TXEMPTY;
      else if (pend_i[P_MODEM])   raw = ID_MODEM;
      else                        raw = ID_NONE;
   end
   assign id_o = {raw[3] & fifo_mode_i, raw[2:0]};
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
   import uart_irq_pkg::*;
#(
   parameter int unsigned FRAME_W     = 4,
   parameter bit          HAS_TIMEOUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_mode,
   input  logic [4:0]         src_en,
   input  logic               line_err,
   input  logic               rx_at_trigger,
   input  logic               rx_nonempty,
   input  logic               rx_push,
   input  logic               rd_rbr,
   input  logic               baud_tick,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic               thr_empty_evt,
   input  logic               wr_thr,
   input  logic               rd_iir,
   input  logic               modem_chg,
   input  logic               rd_lsr,
   input  logic               rd_msr,
   output logic [3:0]         int_id,
   output logic               irq
);
   if (FRAME_W < 2 || FRAME_W > 8) begin : g_bad_frame_w
      $error("uart_irq_id: FRAME_W must be 2..8");
   end

   logic              to_expired;
   logic [FLAG_N-1:0] flag_set, flag_clr, flag_q;
   logic [SRC_N-1:0]  pend;

   if (HAS_TIMEOUT) begin : g_timer
      uart_irq_chartimer #(.FRAME_W(FRAME_W)) u_timer (
         .clk          (clk),
         .rst_n        (rst_n),
         .run_i        (fifo_mode & rx_nonempty),
         .restart_i    (rx_push | rd_rbr),
         .tick_i       (baud_tick),
         .frame_bits_i (frame_bits),
         .expired_o    (to_expired)
      );
   end else begin : g_no_timer
      assign to_expired = 1'b0;
   end

   always_comb begin
      flag_set            = '0;
      flag_clr            = '0;
      flag_set[F_LINE]    = line_err;
      flag_clr[F_LINE]    = rd_lsr;
      flag_set[F_TIMEOUT] = to_expired;
      flag_clr[F_TIMEOUT] = rd_rbr | ~fifo_mode;
      flag_set[F_TXEMPTY] = thr_empty_evt;
      flag_clr[F_TXEMPTY] = wr_thr | (rd_iir && int_id == ID_TXEMPTY);
      flag_set[F_MODEM]   = modem_chg;
      flag_clr[F_MODEM]   = rd_msr;
   end

   uart_irq_flagbank #(.N(FLAG_N)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .flag_o (flag_q)
   );

   always_comb begin
      pend            = '0;
      pend[P_LINE]    = flag_q[F_LINE]    & src_en[P_LINE];
      pend[P_RXDATA]  = rx_at_trigger     & src_en[P_RXDATA];
      pend[P_TIMEOUT] = flag_q[F_TIMEOUT] & src_en[P_TIMEOUT] & fifo_mode;
      pend[P_TXEMPTY] = flag_q[F_TXEMPTY] & src_en[P_TXEMPTY];
      pend[P_MODEM]   = flag_q[F_MODEM]   & src_en[P_MODEM];
   end

   uart_irq_prio u_prio (
      .pend_i      (pend),
      .fifo_mode_i (fifo_mode),
      .id_o        (int_id)
   );

   assign irq = |pend;
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_mode,
   input logic [4:0] src_en,
   input logic       line_err,
   input logic       rd_rbr,
   input logic       thr_empty_evt,
   input logic       wr_thr,
   input logic       rd_iir,
   input logic       modem_chg,
   input logic       rd_msr,
   input logic [3:0] int_id,
   input logic       irq
);
   // R12 (and R1): request line agrees with the "none pending" code bit
   a_r12_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !int_id[0]);

   // R10: time-out code bit never appears outside FIFO mode
   a_r10_no_bit3: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_mode |-> !int_id[3]);

   // R2 / R8: an enabled line error is reported next, above everything
   a_r2_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (line_err && src_en[0]) |=> (!src_en[0] || int_id == 4'b0110));

   // R5: a holding-register write removes the transmit-empty code
   a_r5_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_thr && !thr_empty_evt) |=> int_id != 4'b0010);

   // R6: reading the code while it says transmit-empty retires it
   a_r6_iir_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_iir && int_id == 4'b0010 && !thr_empty_evt) |=> int_id != 4'b0010);

   // R7: modem status read removes the modem cause
   a_r7_msr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_msr && !modem_chg) |=> !(irq && int_id == 4'b0000));

   // R4: a receive-buffer read removes the time-out code
   a_r4_rbr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rbr |=> int_id != 4'b1100);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .src_en(src_en),
   .line_err(line_err), .rd_rbr(rd_rbr), .thr_empty_evt(thr_empty_evt),
   .wr_thr(wr_thr), .rd_iir(rd_iir), .modem_chg(modem_chg),
   .rd_msr(rd_msr), .int_id(int_id), .irq(irq)
);

// File: tb/uart_irq_id_bench.sv
`timescale 1ns/1ps
module uart_irq_id_bench;
   localparam int unsigned FW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fifo_mode, line_err, rx_at_trigger, rx_nonempty, rx_push, rd_rbr;
   logic          baud_tick, thr_empty_evt, wr_thr, rd_iir, modem_chg, rd_lsr, rd_msr;
   logic [4:0]    src_en;
   logic [FW-1:0] frame_bits;
   logic [3:0]    int_id;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   uart_irq_id #(.FRAME_W(FW)) u_uart_irq_id (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .src_en(src_en),
      .line_err(line_err), .rx_at_trigger(rx_at_trigger), .rx_nonempty(rx_nonempty),
      .rx_push(rx_push), .rd_rbr(rd_rbr), .baud_tick(baud_tick), .frame_bits(frame_bits),
      .thr_empty_evt(thr_empty_evt), .wr_thr(wr_thr), .rd_iir(rd_iir),
      .modem_chg(modem_chg), .rd_lsr(rd_lsr), .rd_msr(rd_msr),
      .int_id(int_id), .irq(irq)
   );

   typedef struct packed {
      logic [7:0] req;
      logic [4:0] en;
      logic       trig, lerr, tevt, mchg, rlsr, riir, wthr, rmsr;
      logic [3:0] eid;
      logic       eirq;
   } vec_t;

   // one cycle of stimulus each; expectation sampled one clock later
   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{8'd1,  5'b11111, 0,0,0,0,0,0,0,0, 4'b0001, 0},  // R1 idle
      '{8'd7,  5'b11111, 0,0,0,1,0,0,0,0, 4'b0000, 1},  // R7 modem latched
      '{8'd8,  5'b11111, 0,0,1,0,0,0,0,0, 4'b0010, 1},  // R8 tx-empty above modem
      '{8'd3,  5'b11111, 1,0,0,0,0,0,0,0, 4'b0100, 1},  // R3 data level
      '{8'd2,  5'b11111, 1,1,0,0,0,0,0,0, 4'b0110, 1},  // R2 line highest
      '{8'd2,  5'b11111, 1,0,0,0,1,0,0,0, 4'b0100, 1},  // R2 lsr read clears
      '{8'd3,  5'b11111, 0,0,0,0,0,0,0,0, 4'b0010, 1},  // R3 level dropped
      '{8'd9,  5'b10111, 0,0,0,0,0,0,0,0, 4'b0000, 1},  // R9 tx-empty masked
      '{8'd9,  5'b11111, 0,0,0,0,0,0,0,0, 4'b0010, 1},  // R9 flag kept
      '{8'd6,  5'b11111, 0,0,0,0,0,1,0,0, 4'b0000, 1},  // R6 iir read retires it
      '{8'd5,  5'b11111, 0,0,1,0,0,0,0,0, 4'b0010, 1},  // R5 set again
      '{8'd6,  5'b11111, 1,0,0,0,0,1,0,0, 4'b0100, 1},  // R6 read saw 0100
      '{8'd6,  5'b11111, 0,0,0,0,0,0,0,0, 4'b0010, 1},  // R6 still latched
      '{8'd5,  5'b11111, 0,0,0,0,0,0,1,0, 4'b0000, 1},  // R5 thr write clears
      '{8'd11, 5'b11111, 0,0,0,1,0,0,0,1, 4'b0000, 1},  // R11 set beats clear
      '{8'd7,  5'b11111, 0,0,0,0,0,0,0,1, 4'b0001, 0},  // R7 msr read clears
      '{8'd12, 5'b11110, 0,1,0,0,0,0,0,0, 4'b0001, 0},  // R12 disabled, no irq
      '{8'd9,  5'b11110, 0,0,0,0,1,0,0,0, 4'b0001, 0},  // R9 clear while masked
      '{8'd2,  5'b11111, 0,0,0,0,0,0,0,0, 4'b0001, 0},  // R2 stays cleared
      '{8'd11, 5'b11111, 0,1,0,0,1,0,0,0, 4'b0110, 1},  // R11 line set beats read
      '{8'd2,  5'b11111, 0,0,0,0,1,0,0,0, 4'b0001, 0}   // R2 cleared
   };

   task automatic check(input logic [3:0] e_id, input logic e_irq, input string tag);
      n_chk++;
      if (int_id !== e_id || irq !== e_irq) begin
         n_err++;
         $display("FAIL %s: int_id=%b irq=%b expected int_id=%b irq=%b",
                  tag, int_id, irq, e_id, e_irq);
      end
   endtask

   task automatic idle_strobes();
      line_err = 0; thr_empty_evt = 0; modem_chg = 0; rd_lsr = 0;
      rd_iir = 0; wr_thr = 0; rd_msr = 0; rx_push = 0; rd_rbr = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; fifo_mode = 1; src_en = 5'b11111; rx_at_trigger = 0;
      rx_nonempty = 0; baud_tick = 0; frame_bits = 4'd10;
      idle_strobes();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(4'b0001, 1'b0, "R1 after reset");

      for (int i = 0; i < NV; i++) begin
         src_en = VEC[i].en; rx_at_trigger = VEC[i].trig; line_err = VEC[i].lerr;
         thr_empty_evt = VEC[i].tevt; modem_chg = VEC[i].mchg; rd_lsr = VEC[i].rlsr;
         rd_iir = VEC[i].riir; wr_thr = VEC[i].wthr; rd_msr = VEC[i].rmsr;
         @(negedge clk);
         check(VEC[i].eid, VEC[i].eirq, $sformatf("R%0d vector %0d", VEC[i].req, i));
      end
      idle_strobes(); src_en = 5'b11111; rx_at_trigger = 0;

      // R4 time-out boundary, frame of 10 bits -> limit 40 ticks
      rx_nonempty = 1; rx_push = 1;
      @(negedge clk);
      rx_push = 0; baud_tick = 1;
      repeat (40) @(negedge clk);
      check(4'b0001, 1'b0, "R4 not yet at limit");
      @(negedge clk);
      check(4'b1100, 1'b1, "R4 time-out latched");
      rx_at_trigger = 1;
      #0.5;
      check(4'b0100, 1'b1, "R8 data above time-out");
      rx_at_trigger = 0;
      rd_rbr = 1;
      @(negedge clk);
      rd_rbr = 0;
      check(4'b0001, 1'b0, "R4 rbr read clears");
      repeat (30) @(negedge clk);
      rx_push = 1;
      @(negedge clk);
      rx_push = 0;
      repeat (40) @(negedge clk);
      check(4'b0001, 1'b0, "R4 push restarts count");
      @(negedge clk);
      check(4'b1100, 1'b1, "R4 fires after restart");

      // R10 leaving FIFO mode
      fifo_mode = 0;
      @(negedge clk);
      check(4'b0001, 1'b0, "R10 time-out dropped");
      fifo_mode = 1;
      repeat (2) @(negedge clk);
      check(4'b0001, 1'b0, "R10 stays discarded");
      fifo_mode = 0;
      repeat (60) @(negedge clk);
      check(4'b0001, 1'b0, "R10 no time-out outside FIFO mode");
      baud_tick = 0; rx_nonempty = 0; fifo_mode = 1;

      // R1 reset clears latched causes
      modem_chg = 1;
      @(negedge clk);
      modem_chg = 0;
      check(4'b0000, 1'b1, "R7 modem before reset");
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(4'b0001, 1'b0, "R1 reset clears");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule